// File: doc/BRIEF.md
# SPI Master with Word-Chained Frames

This block is a register-programmed SPI master that can carry frames of any bit length. Software sets the frame through two configuration registers: clock polarity, clock phase, bit order, target channel, frame length, SCLK half-period and a chip-select hold time. A frame longer than one 32-bit word is moved as a chain of words. Software writes a word into the transmit register, waits for the engine to report the pause state, drains the receive register and writes the next word. Chip select stays asserted across the whole chain.

The engine is a small state machine with four named states. IDLE (code 0) waits for a transmit write. SHIFT (code 1) clocks one word out and in. PAUSE (code 4) sits mid-frame with chip select held, waiting for the next word. HOLD (code 2) keeps chip select asserted for the programmed wait before the engine returns to IDLE. The transitions are:

- IDLE→SHIFT on a transmit write when the length is non-zero.
- SHIFT→PAUSE after the last edge of a word when more bits remain.
- SHIFT→HOLD after the last edge of the final word.
- PAUSE→SHIFT on a transmit write.
- HOLD→IDLE when the wait count expires.

Channel 31 is a self-test channel that feeds MOSI straight back into the receiver.

Top module: `spi_word_master`

## Requirements
- R1: After reset, the status state code is 0, every cs_n bit is 1, sclk is 0, and the config, transmit and receive registers read 0.
- R2: The register addresses are 0 config-A, 1 config-B, 2 transmit word, 3 receive word and 4 status. Config-A holds polarity at bit 31, phase at bit 30, LSB-first at bit 29, channel at [20:16] and length in bits at [15:0]. Config-B holds the half-period in system clocks at [31:16] (0 acts as 1) and the wait count at [15:0]. Both config registers read back as written. A write to either is ignored unless the state is 0.
- R3: When not in SHIFT, sclk rests at the polarity level. In SHIFT it toggles every H clocks, with the first toggle H clocks after the accepting write, and it makes exactly 2n toggles for an n-bit word.
- R4: With phase 0, the input is sampled on odd-numbered edges and MOSI advances on even-numbered edges. With phase 1, MOSI advances on odd edges from the third edge on, and the input is sampled on even edges.
- R5: MSB-first words hold n = (remaining mod 32, or 32 if that is 0) bits, right-aligned. They are sent from bit n-1 down, and received bits land right-aligned, with the first received bit in bit n-1.
- R6: LSB-first words hold n = min(32, remaining) bits. They are sent from bit 0 up, and received bits land left-aligned in bits 31 down to 32-n.
- R7: Between words of a frame the state is 4, chip select stays asserted and sclk rests. A transmit write resumes shifting, with the same timing as the first word.
- R8: A transmit write while the state is 1 or 2 has no effect on the data sent or received.
- R9: After the final word, the state is 2 and chip select stays asserted for wait+1 clocks. Then the state is 0 and all cs_n bits are 1.
- R10: cs_n is active-low and one-hot on the programmed channel while a frame is open. A channel of NCS or above, including 31, drives no pin.
- R11: On channel 31 the receiver takes MOSI and ignores miso. On any other channel it takes miso.
- R12: The receive register is cleared when a word starts and does not change outside SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The bench checks a partial first word in MSB-first mode and a partial last word in LSB-first mode. A design that sized the word from the wrong end would send the wrong bit count, and the receive alignment would come back shifted. All four polarity and phase combinations are run and compared edge by edge. An off-by-one in the CPHA=1 advance rule would show as MOSI changing one edge early. The bench also writes into the transmit and config registers during shifting, runs a zero half-period setting, and uses a channel with no pin. Loopback is told apart from the external path because the bench drives miso with the inverse of MOSI, so a design that loops back on the wrong channel returns complemented data.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int DIV_W  = 16;
    localparam int WAIT_W = 16;
    localparam int CH_W   = 5;

    localparam logic [2:0] ADDR_CFGA   = 3'd0;
    localparam logic [2:0] ADDR_CFGB   = 3'd1;
    localparam logic [2:0] ADDR_TX     = 3'd2;
    localparam logic [2:0] ADDR_RX     = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;

    localparam int POS_CPOL = 31;
    localparam int POS_CPHA = 30;
    localparam int POS_LSB  = 29;
    localparam int POS_CH   = 16;
    localparam int POS_HALF = 16;
    localparam int POS_STAT = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_HOLD  = 3'd2,
        ST_PAUSE = 3'd4
    } eng_state_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = (half == '0) ? '0 : half - CNT_W'(1);
        tick  = run && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NCS     = 8,
    parameter int CH_W    = 5,
    parameter int LOOP_CH = 31
) (
    input  logic            active,
    input  logic [CH_W-1:0] chan,
    output logic [NCS-1:0]  cs_n,
    output logic            loop_sel
);
    assign loop_sel = (chan == CH_W'(LOOP_CH));

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        if (i == LOOP_CH) begin : g_none
            assign cs_n[i] = 1'b1;
        end else begin : g_pin
            assign cs_n[i] = !(active && (chan == CH_W'(i)));
        end
    end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int NCS     = 8,
    parameter int LOOP_CH = 31
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [2:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    localparam int LOG_W  = $clog2(WORD_W);
    localparam int CNT_W  = LOG_W + 1;
    localparam int EDGE_W = CNT_W + 1;

    eng_state_e         st_q, st_d;
    logic [WORD_W-1:0]  cfga_q, cfgb_q, tx_q, rx_q;
    logic [EDGE_W-1:0]  edge_q;
    logic [CNT_W-1:0]   nbits_q;
    logic [LEN_W-1:0]   remain_q;
    logic [WAIT_W-1:0]  wait_q;
    logic               ph_q;

    logic               cpol, cpha, lsb_first;
    logic [CH_W-1:0]    chan;
    logic [LEN_W-1:0]   flen;
    logic [DIV_W-1:0]   half;
    logic [WAIT_W-1:0]  wait_lim;

    logic               tick, loop_sel, tx_wr, accept;
    logic               last_edge, final_word, sample_now, rx_bit;
    logic [LEN_W-1:0]   rem_src;
    logic [CNT_W-1:0]   n_start;
    logic [EDGE_W-1:0]  edge_m1, last_idx;
    logic [CNT_W-1:0]   bit_k, bit_idx;

    assign cpol      = cfga_q[POS_CPOL];
    assign cpha      = cfga_q[POS_CPHA];
    assign lsb_first = cfga_q[POS_LSB];
    assign chan      = cfga_q[POS_CH +: CH_W];
    assign flen      = cfga_q[LEN_W-1:0];
    assign half      = cfgb_q[POS_HALF +: DIV_W];
    assign wait_lim  = cfgb_q[WAIT_W-1:0];

    spi_half_timer #(.CNT_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q == ST_SHIFT),
        .half  (half),
        .tick  (tick)
    );

    spi_cs_decode #(.NCS(NCS), .CH_W(CH_W), .LOOP_CH(LOOP_CH)) u_csdec (
        .active   (st_q != ST_IDLE),
        .chan     (chan),
        .cs_n     (cs_n),
        .loop_sel (loop_sel)
    );

    // word control
    always_comb begin
        tx_wr   = reg_wr && (reg_addr == ADDR_TX);
        accept  = tx_wr && (((st_q == ST_IDLE) && (flen != '0)) || (st_q == ST_PAUSE));
        rem_src = (st_q == ST_IDLE) ? flen : remain_q;
        if (lsb_first) begin
            n_start = (rem_src >= LEN_W'(WORD_W)) ? CNT_W'(WORD_W) : CNT_W'(rem_src);
        end else begin
            n_start = (rem_src[LOG_W-1:0] == '0) ? CNT_W'(WORD_W)
                                                  : {1'b0, rem_src[LOG_W-1:0]};
        end
        last_idx   = {nbits_q, 1'b0} - EDGE_W'(1);
        last_edge  = tick && (edge_q == last_idx);
        final_word = (remain_q == LEN_W'(nbits_q));
        sample_now = tick && (cpha ? edge_q[0] : !edge_q[0]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_SHIFT;
            ST_SHIFT: if (last_edge) st_d = final_word ? ST_HOLD : ST_PAUSE;
            ST_PAUSE: if (accept) st_d = ST_SHIFT;
            ST_HOLD:  if (wait_q == wait_lim) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfga_q   <= '0;
            cfgb_q   <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            edge_q   <= '0;
            nbits_q  <= '0;
            remain_q <= '0;
            wait_q   <= '0;
            ph_q     <= 1'b0;
        end else begin
            if (reg_wr && (st_q == ST_IDLE)) begin
                if (reg_addr == ADDR_CFGA) cfga_q <= reg_wdata;
                if (reg_addr == ADDR_CFGB) cfgb_q <= reg_wdata;
            end
            if (accept) begin
                tx_q    <= reg_wdata;
                rx_q    <= '0;
                edge_q  <= '0;
                ph_q    <= 1'b0;
                nbits_q <= n_start;
                if (st_q == ST_IDLE) remain_q <= flen;
            end else if ((st_q == ST_SHIFT) && tick) begin
                ph_q   <= ~ph_q;
                edge_q <= edge_q + EDGE_W'(1);
                if (sample_now) begin
                    if (lsb_first) rx_q <= {rx_bit, rx_q[WORD_W-1:1]};
                    else           rx_q <= {rx_q[WORD_W-2:0], rx_bit};
                end
                if (last_edge) begin
                    remain_q <= remain_q - LEN_W'(nbits_q);
                    wait_q   <= '0;
                end
            end else if (st_q == ST_HOLD) begin
                wait_q <= wait_q + WAIT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        edge_m1 = edge_q - EDGE_W'(1);
        if (cpha) bit_k = (edge_q == '0) ? '0 : edge_m1[EDGE_W-1:1];
        else      bit_k = edge_q[EDGE_W-1:1];
        bit_idx = lsb_first ? bit_k : (nbits_q - CNT_W'(1) - bit_k);
        mosi    = (st_q == ST_SHIFT) ? tx_q[bit_idx[LOG_W-1:0]] : 1'b0;
        rx_bit  = loop_sel ? mosi : miso;
        sclk    = cpol ^ ph_q;
        unique case (reg_addr)
            ADDR_CFGA:   reg_rdata = cfga_q;
            ADDR_CFGB:   reg_rdata = cfgb_q;
            ADDR_TX:     reg_rdata = tx_q;
            ADDR_RX:     reg_rdata = rx_q;
            ADDR_STATUS: reg_rdata = {13'd0, st_q, 16'd0};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk #(
    parameter int NCS = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     st,
    input logic [NCS-1:0] cs_n,
    input logic           sclk,
    input logic [31:0]    cfga,
    input logic [31:0]    rx,
    input logic           reg_wr,
    input logic [2:0]     reg_addr
);
    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0 || st == 3'd1 || st == 3'd2 || st == 3'd4)); // R7

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R10

    AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0) |-> (&cs_n)); // R9

    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'd1) |-> (sclk == cfga[31])); // R3

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'd1) |=> (st == 3'd1 || $stable(rx))); // R12

    AST_PAUSE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd4 && !(reg_wr && reg_addr == 3'd2)) |=> (st == 3'd4)); // R7

    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'd0) |=> $stable(cfga)); // R2
endmodule

bind spi_word_master spi_word_master_chk #(.NCS(NCS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_q),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .cfga     (cfga_q),
    .rx       (rx_q),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr)
);

// File: tb/spi_word_master_bench.sv
`timescale 1ns/1ps
module spi_word_master_bench;
    localparam int NCS = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [2:0]     reg_addr = 3'd0;
    logic [31:0]    reg_wdata = 32'd0;
    logic [31:0]    reg_rdata;
    logic           sclk, mosi, miso;
    logic [NCS-1:0] cs_n;
    int n_chk = 0;
    int n_fail = 0;

    assign miso = ~mosi;

    always #2 clk = ~clk;

    spi_word_master #(.NCS(NCS)) u_spi_word_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [NCS-1:0] exp_cs(input int ch, input bit active);
        logic [NCS-1:0] v;
        for (int i = 0; i < NCS; i++) v[i] = !(active && ch == i && ch != 31);
        return v;
    endfunction

    task automatic cyc_check(input string req, input int est, input bit esclk,
                             input logic [NCS-1:0] ecs, input bit do_mosi, input bit emosi);
        logic [31:0] s;
        reg_read(3'd4, s);
        check({req, " state"}, 32'((s >> 16) & 32'h7), 32'(est));
        check({req, " sclk"}, 32'(sclk), 32'(esclk));
        check("R10 cs_n", 32'(cs_n), 32'(ecs));
        if (do_mosi) check("R4 mosi", 32'(mosi), 32'(emosi));
    endtask

    task automatic run_word(input bit cpol, input bit cpha, input bit lsb, input int ch,
                            input int n, input int h, input int wt, input logic [31:0] w,
                            input bit last, input bit poke);
        int edges, k, idx;
        logic [31:0] rxe, rxa;
        bit b;
        bit ext = (ch != 31);
        bus_write(3'd2, w);
        cyc_check("R3", 1, cpol, exp_cs(ch, 1), 1, lsb ? w[0] : w[n-1]);
        for (int m = 1; m <= 2 * n * h; m++) begin
            if (poke && m == 1) begin
                reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = ~w;   // R8 ignored write
            end else if (poke && m == 3) begin
                reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0; // R2 locked config
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
            reg_wr = 1'b0;
            edges = m / h;
            k = cpha ? ((edges == 0) ? 0 : (edges - 1) / 2) : edges / 2;
            idx = lsb ? k : n - 1 - k;
            if (m < 2 * n * h)
                cyc_check("R3", 1, cpol ^ edges[0], exp_cs(ch, 1), 1, w[idx]);
            else
                cyc_check("R7", last ? 2 : 4, cpol, exp_cs(ch, 1), 0, 1'b0);
        end
        rxe = 32'h0;
        for (int j = 0; j < n; j++) begin
            b = lsb ? w[j] : w[n-1-j];
            if (ext) b = ~b;
            if (lsb) rxe[32-n+j] = b;
            else     rxe[n-1-j] = b;
        end
        reg_read(3'd3, rxa);
        check(lsb ? "R6 R11 rx word" : "R5 R11 rx word", rxa, rxe);
        if (last) begin
            for (int j = 1; j <= wt + 1; j++) begin
                @(negedge clk);
                cyc_check("R9", (j == wt + 1) ? 0 : 2, cpol, exp_cs(ch, j <= wt), 0, 1'b0);
            end
            reg_read(3'd3, rxa);
            check("R12 rx held", rxa, rxe);
        end else begin
            @(negedge clk);
            cyc_check("R7", 4, cpol, exp_cs(ch, 1), 0, 1'b0);
        end
    endtask

    task automatic run_frame(input bit cpol, input bit cpha, input bit lsb, input int ch,
                             input int len, input int hf, input int wt,
                             input logic [127:0] data, input bit poke);
        logic [31:0] c1, c2, rd, w;
        logic [127:0] sh;
        int rem, n, h;
        bit first = 1;
        c1 = {cpol, cpha, lsb, 8'd0, 5'(ch), 16'(len)};
        c2 = {16'(hf), 16'(wt)};
        bus_write(3'd0, c1);
        bus_write(3'd1, c2);
        reg_read(3'd0, rd); check("R2 cfgA readback", rd, c1);
        reg_read(3'd1, rd); check("R2 cfgB readback", rd, c2);
        h = (hf == 0) ? 1 : hf;
        rem = len;
        while (rem > 0) begin
            if (lsb) n = (rem >= 32) ? 32 : rem;
            else     n = (rem % 32 == 0) ? 32 : rem % 32;
            sh = lsb ? (data >> (len - rem)) : (data >> (rem - n));
            w = (n == 32) ? sh[31:0] : (sh[31:0] & ((32'h1 << n) - 32'h1));
            run_word(cpol, cpha, lsb, ch, n, h, wt, w, rem == n, poke && first);
            first = 0;
            rem -= n;
        end
        if (poke) begin
            reg_read(3'd0, rd);
            check("R2 cfgA unchanged after busy write", rd, c1);
        end
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        reg_read(3'd4, rd); check("R1 status", rd, 32'h0);
        reg_read(3'd3, rd); check("R1 rx", rd, 32'h0);
        reg_read(3'd0, rd); check("R1 cfgA", rd, 32'h0);
        check("R1 cs_n", 32'(cs_n), 32'(exp_cs(0, 0)));
        check("R1 sclk", 32'(sclk), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(3'd4, rd); check("R1 status after release", rd, 32'h0);

        run_frame(0, 0, 0, 2,  8,  2, 3, 128'haa, 0);
        run_frame(0, 1, 0, 31, 12, 0, 0, 128'h5c3, 0);
        run_frame(1, 0, 1, 5,  40, 3, 2, 128'h9e_1234abcd, 0);
        run_frame(1, 1, 1, 31, 70, 1, 1, 128'h2b_f00dcafe_13579bdf, 0);
        run_frame(1, 1, 0, 7,  64, 2, 4, 128'h80000001_c3c3a5a5, 1);
        run_frame(0, 0, 0, 20, 5,  1, 0, 128'h15, 0);
        run_frame(0, 0, 1, 31, 37, 2, 1, 128'h1f_0f0f0f0f, 1);

        summary();
        $finish;
    end
endmodule